// File: doc/BRIEF.md
# Serial NOR Flash User-Mode Command Sequencer

The block lets software drive a serial NOR flash byte by byte. A single control register write enters or leaves software-driven ("user") access, picks how many IO lanes the serial bus uses, turns the address phase on or off, and holds or releases chip select. While the flash is selected, the host pushes bytes through a valid/ready byte stream, and the block shifts each one out on the serial pins with the most significant bit first.

The block also follows the traffic. The first byte after each new selection is decoded as a flash opcode. From a small table the block learns how many address bytes follow that opcode and how many dummy slots must come after the address. It then inserts those dummy slots on its own, with the bus released. Decoding restarts only when chip select really goes from released to asserted. A control write that leaves the selection as it is (for example one that only switches the lane count) does not make the next host byte count as a new opcode.

Back-pressure rules: `s_ready` is high only while the flash is selected, no byte or dummy slot is being shifted, and no dummy slot is still owed. A byte is taken on a clock edge where `s_valid` and `s_ready` are both high. While `s_valid` is high and `s_ready` is low, the host must hold `s_data` steady.

Top module: `sfc_user_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `s_ready` is 0 and `spi_sck` is 0.
- R2: A control write with bits [1:0] = 2'b11 and bit 2 = 0 drives `spi_cs_n` low from the next clock. A write with any other value in bits [1:0], or with bit 2 = 1, drives it high. `spi_cs_n` changes on no other clock.
- R3: Control bit 31 set selects four lanes (io[3] carries the byte's bit 7 on the first beat). Otherwise bit 30 set selects two lanes (io[1] carries bit 7). Otherwise one lane is used (io[0] carries bit 7). Each beat shifts the byte toward its MSB.
- R4: Each beat lasts two clocks: data is set while `spi_sck` is low, and `spi_sck` is high for exactly one clock. On a data beat `spi_io_oe` is 4'b0001, 4'b0011 or 4'b1111 for one, two or four lanes.
- R5: `s_ready` follows the back-pressure rules above. It is low while a byte or dummy slot is in flight and while the flash is deselected.
- R6: The first byte accepted after `spi_cs_n` falls is decoded as an opcode. When the address phase is enabled, the table's number of address bytes follows it, then the table's number of dummy slots, then data.
- R7: Opcode table (address bytes, dummy slots): 03h(3,0), 0Bh(3,1), 0Ch(4,1), 02h(3,0), 12h(4,0), 32h(3,0), 34h(4,0), 6Bh(3,1), 6Ch(4,1), EBh(3,3). The four-byte fast read 0Ch uses the same single dummy slot as 0Bh.
- R8: An opcode not in the table (for example 9Fh or 00h) has no address phase and no dummy slot. Every following byte is data.
- R9: Control bit 3 = 1 disables the address phase. The opcode is then followed directly by its dummy slots, if any, and then by data.
- R10: A control write that keeps the flash selected (including one that only changes the lane bits) neither toggles `spi_cs_n` nor restarts decoding. A later data byte equal to an opcode goes out as data and no dummy slot is added.
- R11: After a deselect and a fresh selection, decoding restarts with the first new byte.
- R12: A dummy slot lasts one byte time at the current lane count, with `spi_io_oe` = 0 on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write value |
| s_valid | input | 1 | Host byte valid |
| s_ready | output | 1 | Block can take a host byte |
| s_data | input | 8 | Host byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_io_o | output | IO_W | Serial data lanes out |
| spi_io_oe | output | IO_W | Per-lane output enable |

## Verification
The main target is a lane-count change in the middle of a selected transfer, followed by a data byte equal to an opcode that needs dummy slots. A design that restarts decoding on every control write would send an extra dummy slot there. A design that pulses chip select on such a write would show a glitch on `spi_cs_n`. The bench also sweeps every table opcode plus unknown ones, across all three lane counts and both address settings. A wrong table entry, a 0Ch/0Bh mismatch, or a skipped address phase shows up as a missing, extra or misplaced dummy slot in the decoded serial stream. Wrong lane ordering shows up as corrupted bytes.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int OPC_W = 8;
  localparam int CNT_W = 3;

  typedef enum logic [2:0] {SN_OFF, SN_START, SN_ADDR, SN_DUMMY, SN_DATA} snoop_t;
  typedef enum logic [1:0] {LN_X1 = 2'd0, LN_X2 = 2'd1, LN_X4 = 2'd2} lane_t;

  typedef struct packed {
    logic [CNT_W-1:0] abytes;
    logic [CNT_W-1:0] dslots;
  } op_info_t;

  function automatic op_info_t op_lookup(input logic [OPC_W-1:0] op);
    op_info_t r;
    case (op)
      8'h03, 8'h02, 8'h32: r = '{abytes: 3'd3, dslots: 3'd0};
      8'h12, 8'h34:        r = '{abytes: 3'd4, dslots: 3'd0};
      8'h0B, 8'h6B:        r = '{abytes: 3'd3, dslots: 3'd1};
      8'h0C, 8'h6C:        r = '{abytes: 3'd4, dslots: 3'd1};
      8'hEB:               r = '{abytes: 3'd3, dslots: 3'd3};
      default:             r = '{abytes: 3'd0, dslots: 3'd0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sfc_ctl_reg.sv
module sfc_ctl_reg
  import sfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic        sel,
  output logic        sel_rise,
  output logic        sel_fall,
  output lane_t       lanes,
  output logic        addr_en
);
  logic  unsel_q;
  logic  new_unsel;
  lane_t lanes_q;
  lane_t lanes_d;
  logic  addr_off_q;

  assign new_unsel = (wdata[1:0] != 2'b11) || wdata[2];

  always_comb begin
    if (wdata[31])      lanes_d = LN_X4;
    else if (wdata[30]) lanes_d = LN_X2;
    else                lanes_d = LN_X1;
  end

  assign sel_rise = wr_en && unsel_q && !new_unsel;
  assign sel_fall = wr_en && !unsel_q && new_unsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unsel_q    <= 1'b1;
      lanes_q    <= LN_X1;
      addr_off_q <= 1'b0;
    end else if (wr_en) begin
      lanes_q    <= lanes_d;
      addr_off_q <= wdata[3];
      if (new_unsel != unsel_q) unsel_q <= new_unsel;
    end
  end

  assign sel     = !unsel_q;
  assign lanes   = lanes_q;
  assign addr_en = !addr_off_q;

  // R2
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(sel));

  // R10
  sel_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(sel) && ($past(wdata[2:0]) == 3'b011)) |-> sel);
endmodule

// File: rtl/sfc_snoop.sv
module sfc_snoop
  import sfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_rise,
  input  logic             sel_fall,
  input  logic             addr_en,
  input  logic             byte_acc,
  input  logic [OPC_W-1:0] byte_in,
  input  logic             slot_done,
  output snoop_t           state
);
  snoop_t           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dum_q;
  op_info_t         info;

  assign info = op_lookup(byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SN_OFF;
      cnt_q <= '0;
      dum_q <= '0;
    end else if (sel_fall) begin
      st_q <= SN_OFF;
    end else if (sel_rise) begin
      st_q <= SN_START;
    end else begin
      case (st_q)
        SN_START: if (byte_acc) begin
          dum_q <= info.dslots;
          if (addr_en && info.abytes != '0) begin
            st_q  <= SN_ADDR;
            cnt_q <= info.abytes;
          end else if (info.dslots != '0) begin
            st_q  <= SN_DUMMY;
            cnt_q <= info.dslots;
          end else begin
            st_q <= SN_DATA;
          end
        end
        SN_ADDR: if (byte_acc) begin
          if (cnt_q == 1) begin
            if (dum_q != '0) begin
              st_q  <= SN_DUMMY;
              cnt_q <= dum_q;
            end else begin
              st_q <= SN_DATA;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SN_DUMMY: if (slot_done) begin
          if (cnt_q == 1) st_q <= SN_DATA;
          else            cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign state = st_q;

  // R12
  no_byte_in_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SN_DUMMY) |-> !byte_acc);

  // R7
  addr_then_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == SN_ADDR && st_q == SN_DUMMY) |-> (cnt_q == $past(dum_q)));
endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter
  import sfc_pkg::*;
#(
  parameter int IO_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_dummy,
  input  logic [OPC_W-1:0] din,
  input  lane_t            lanes,
  output logic             busy,
  output logic             dummy_done,
  output logic             sck,
  output logic [IO_W-1:0]  io_o,
  output logic [IO_W-1:0]  io_oe
);
  localparam int BEAT_W = $clog2(OPC_W) + 1;

  logic [OPC_W-1:0]  sh_q;
  logic [BEAT_W-1:0] beats_q;
  logic              busy_q;
  logic              sck_q;
  logic              dummy_q;
  lane_t             code_q;
  int                step;

  assign step = 1 << code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      beats_q <= '0;
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      dummy_q <= 1'b0;
      code_q  <= LN_X1;
    end else if (!busy_q) begin
      if (load || load_dummy) begin
        busy_q  <= 1'b1;
        sck_q   <= 1'b0;
        sh_q    <= load ? din : '1;
        dummy_q <= !load;
        code_q  <= lanes;
        beats_q <= BEAT_W'(OPC_W >> lanes);
      end
    end else if (!sck_q) begin
      sck_q <= 1'b1;
    end else begin
      sck_q   <= 1'b0;
      sh_q    <= sh_q << step;
      beats_q <= beats_q - 1'b1;
      if (beats_q == 1) busy_q <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < IO_W; gi++) begin : g_lane
    always_comb begin
      if (gi < step) begin
        io_o[gi]  = sh_q[OPC_W - step + gi];
        io_oe[gi] = busy_q && !dummy_q;
      end else begin
        io_o[gi]  = 1'b0;
        io_oe[gi] = 1'b0;
      end
    end
  end

  assign busy       = busy_q;
  assign sck        = sck_q;
  assign dummy_done = busy_q && sck_q && (beats_q == 1) && dummy_q;

  // R4
  sck_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |=> !sck_q);

  // R5
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load || load_dummy) |-> !busy_q);
endmodule

// File: rtl/sfc_user_seq.sv
module sfc_user_seq
  import sfc_pkg::*;
#(
  parameter int IO_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  logic [31:0]     ctl_wdata,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [7:0]      s_data,
  output logic            spi_cs_n,
  output logic            spi_sck,
  output logic [IO_W-1:0] spi_io_o,
  output logic [IO_W-1:0] spi_io_oe
);
  logic   sel, sel_rise, sel_fall, addr_en;
  lane_t  lanes;
  snoop_t snoop_st;
  logic   busy, dummy_done, byte_acc, start_dummy;

  sfc_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wdata(ctl_wdata),
    .sel(sel), .sel_rise(sel_rise), .sel_fall(sel_fall),
    .lanes(lanes), .addr_en(addr_en)
  );

  assign s_ready = sel && !busy &&
                   (snoop_st == SN_START || snoop_st == SN_ADDR || snoop_st == SN_DATA);
  assign byte_acc    = s_valid && s_ready;
  assign start_dummy = !busy && (snoop_st == SN_DUMMY);

  sfc_snoop u_snoop (
    .clk(clk), .rst_n(rst_n), .sel_rise(sel_rise), .sel_fall(sel_fall),
    .addr_en(addr_en), .byte_acc(byte_acc), .byte_in(s_data),
    .slot_done(dummy_done), .state(snoop_st)
  );

  sfc_shifter #(.IO_W(IO_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(byte_acc), .load_dummy(start_dummy),
    .din(s_data), .lanes(lanes), .busy(busy), .dummy_done(dummy_done),
    .sck(spi_sck), .io_o(spi_io_o), .io_oe(spi_io_oe)
  );

  assign spi_cs_n = !sel;

  // R6
  fresh_sel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (snoop_st == SN_START));

  // R11
  desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (snoop_st == SN_OFF));
endmodule

// File: tb/sfc_user_seq_bench.sv
module sfc_user_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_ready, spi_cs_n, spi_sck;
  logic [3:0] spi_io_o, spi_io_oe;

  always #5 clk = ~clk;

  sfc_user_seq u_sfc_user_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe)
  );

  int tests = 0, fails = 0;
  int lanes = 1;
  logic [7:0] log_v [0:31];
  logic       log_d [0:31];
  int         log_n = 0;
  logic [7:0] exp_v [0:31];
  logic       exp_d [0:31];
  int         exp_n = 0;
  logic [7:0] acc = '0;
  int  beat_i = 0;
  logic slot_dum = 1'b0;
  logic prev_sck = 1'b0;
  int  hi_run = 0;
  int  bad_sck = 0, bad_oe = 0;
  logic hold_sel = 1'b0;
  int  cs_glitch = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // serial stream decoder, sampled mid-cycle
  always @(negedge clk) begin
    if (hold_sel && spi_cs_n) cs_glitch++;
    if (spi_sck) hi_run++; else hi_run = 0;
    if (hi_run > 1) bad_sck++;
    if (spi_sck && !prev_sck) begin
      logic [3:0] pat;
      pat = 4'((1 << lanes) - 1);
      if (spi_io_oe != 4'b0 && spi_io_oe != pat) bad_oe++;
      if (beat_i == 0) slot_dum = (spi_io_oe == 4'b0);
      else if (slot_dum != (spi_io_oe == 4'b0)) bad_oe++;
      acc = 8'((acc << lanes) | (spi_io_o & pat));
      beat_i++;
      if (beat_i == 8 / lanes) begin
        if (log_n < 32) begin
          log_v[log_n] = acc;
          log_d[log_n] = slot_dum;
        end
        log_n++;
        beat_i = 0;
        acc = '0;
      end
    end
    prev_sck = spi_sck;
  end

  function automatic int lanes_of(input logic [31:0] v);
    if (v[31]) return 4;
    if (v[30]) return 2;
    return 1;
  endfunction

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    lanes = lanes_of(v);
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    s_valid = 1'b1;
    s_data = b;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (80) @(negedge clk);
  endtask

  task automatic exp_push(input logic d, input logic [7:0] v);
    exp_d[exp_n] = d;
    exp_v[exp_n] = v;
    exp_n++;
  endtask

  task automatic fresh(input logic [31:0] v);
    wr_ctl(32'h7);
    wr_ctl(v);
    log_n = 0;
    exp_n = 0;
  endtask

  task automatic compare(input string req, input string what);
    bit ok;
    ok = (log_n == exp_n);
    for (int i = 0; i < exp_n && i < 32; i++) begin
      if (log_d[i] != exp_d[i]) ok = 0;
      if (!exp_d[i] && log_v[i] != exp_v[i]) ok = 0;
    end
    check(ok, req, what, 32'(log_n), 32'(exp_n));
  endtask

  // table from R7, unknown per R8
  task automatic table_of(input logic [7:0] op, output int ab, output int dn);
    case (op)
      8'h03, 8'h02, 8'h32: begin ab = 3; dn = 0; end
      8'h12, 8'h34:        begin ab = 4; dn = 0; end
      8'h0B, 8'h6B:        begin ab = 3; dn = 1; end
      8'h0C, 8'h6C:        begin ab = 4; dn = 1; end
      8'hEB:               begin ab = 3; dn = 3; end
      default:             begin ab = 0; dn = 0; end
    endcase
  endtask

  function automatic logic [7:0] op_at(input int i);
    case (i)
      0: return 8'h03;  1: return 8'h0B;  2: return 8'h0C;  3: return 8'h02;
      4: return 8'h12;  5: return 8'h32;  6: return 8'h34;  7: return 8'h6B;
      8: return 8'h6C;  9: return 8'hEB;  10: return 8'h9F; default: return 8'h00;
    endcase
  endfunction

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(spi_cs_n == 1'b1, "R1", "cs_n in reset", 32'(spi_cs_n), 1);
    check(s_ready == 1'b0, "R1", "s_ready in reset", 32'(s_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n == 1'b1 && s_ready == 1'b0 && spi_sck == 1'b0, "R1", "idle after reset",
          {29'b0, spi_cs_n, s_ready, spi_sck}, 32'h4);

    // R2 hardware-managed mode keeps the flash deselected
    wr_ctl(32'h1);
    check(spi_cs_n == 1'b1, "R2", "cs_n with mode 01", 32'(spi_cs_n), 1);

    // R2 and R5: selection and readiness
    fresh(32'h3);
    check(spi_cs_n == 1'b0, "R2", "cs_n after user select", 32'(spi_cs_n), 0);
    check(s_ready == 1'b1, "R5", "ready when selected", 32'(s_ready), 1);

    // R10: lane change mid transfer must not restart decoding
    send(8'h0B);
    check(s_ready == 1'b0, "R5", "ready low while shifting", 32'(s_ready), 0);
    send(8'h01); send(8'h02); send(8'h03);
    drain();
    hold_sel = 1'b1;
    wr_ctl(32'h8000_0003);
    send(8'h0B); send(8'h34); send(8'h0B);
    drain();
    hold_sel = 1'b0;
    exp_push(0, 8'h0B); exp_push(0, 8'h01); exp_push(0, 8'h02); exp_push(0, 8'h03);
    exp_push(1, 8'h00);
    exp_push(0, 8'h0B); exp_push(0, 8'h34); exp_push(0, 8'h0B);
    compare("R10", "stream across lane change");
    check(cs_glitch == 0, "R10", "cs_n held across lane write", 32'(cs_glitch), 0);

    // R10: 4-byte quad program, data equal to the opcode passes through
    fresh(32'h8000_0003);
    send(8'h34); send(8'hC0); send(8'hC1); send(8'hC2); send(8'hC3);
    drain();
    wr_ctl(32'h8000_0003);
    send(8'h34); send(8'hEB);
    drain();
    exp_push(0, 8'h34); exp_push(0, 8'hC0); exp_push(0, 8'hC1); exp_push(0, 8'hC2);
    exp_push(0, 8'hC3); exp_push(0, 8'h34); exp_push(0, 8'hEB);
    compare("R10", "quad program no extra slots");

    // R2 stop bit releases; R5 ready drops
    wr_ctl(32'h7);
    check(spi_cs_n == 1'b1, "R2", "cs_n after stop bit", 32'(spi_cs_n), 1);
    check(s_ready == 1'b0, "R5", "ready low deselected", 32'(s_ready), 0);

    // R11: fresh selection restarts decoding (two lanes, R3)
    wr_ctl(32'h4000_0003);
    log_n = 0; exp_n = 0;
    send(8'h0C); send(8'hA0); send(8'hA1); send(8'hA2); send(8'hA3); send(8'h0C);
    drain();
    exp_push(0, 8'h0C); exp_push(0, 8'hA0); exp_push(0, 8'hA1); exp_push(0, 8'hA2);
    exp_push(0, 8'hA3); exp_push(1, 8'h00); exp_push(0, 8'h0C);
    compare("R11", "reselect decodes 0C on two lanes");

    // R8: unknown opcode
    fresh(32'h3);
    send(8'h9F); send(8'h0B); send(8'h01);
    drain();
    exp_push(0, 8'h9F); exp_push(0, 8'h0B); exp_push(0, 8'h01);
    compare("R8", "unknown opcode then data");

    // R9: address phase disabled
    fresh(32'hB);
    send(8'h0B); send(8'h55);
    drain();
    exp_push(0, 8'h0B); exp_push(1, 8'h00); exp_push(0, 8'h55);
    compare("R9", "fast read with address off");

    // R6 R7 R12 R3: sweep opcodes x lanes x address setting
    for (int oi = 0; oi < 12; oi++) begin
      for (int li = 0; li < 3; li++) begin
        for (int ae = 0; ae < 2; ae++) begin
          logic [31:0] cv;
          logic [7:0]  op;
          int ab, dn;
          op = op_at(oi);
          cv = 32'h3 | (li == 2 ? 32'h8000_0000 : (li == 1 ? 32'h4000_0000 : 32'h0))
                     | (ae == 0 ? 32'h8 : 32'h0);
          table_of(op, ab, dn);
          fresh(cv);
          exp_push(0, op);
          send(op);
          if (ae == 1) begin
            for (int k = 0; k < ab; k++) begin
              send(8'(8'h10 + oi * 8 + k));
              exp_push(0, 8'(8'h10 + oi * 8 + k));
            end
          end
          for (int k = 0; k < dn; k++) exp_push(1, 8'h00);
          send(op);      exp_push(0, op);
          send(8'h5A);   exp_push(0, 8'h5A);
          drain();
          compare("R7", $sformatf("sweep op=%0h lanes=%0d addr=%0d", op, lanes, ae));
        end
      end
    end

    check(bad_sck == 0, "R4", "sck high one clock", 32'(bad_sck), 0);
    check(bad_oe == 0, "R12", "oe pattern per slot", 32'(bad_oe), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule